// File: doc/BRIEF.md
# Transmit Holding Register Control

This block is the transmit-side front end of one serial channel. It holds a single character written by the processor. It passes that character to a downstream transmit shift register, which is modelled only as an idle/load handshake. It also produces the transmitter-ready status that tells software the holding stage can take another character.

The enable input controls the whole stage. While the transmitter is disabled, ready stays low and the holding stage is kept empty. Any write made in that state, and any character already held, is dropped and never sent. When the transmitter is enabled, ready goes high in the same cycle. Bit serialization, framing, baud timing and interrupt generation belong to other blocks.

Top module: `txhold_ctrl`

## Requirements
- R1: After reset the holding stage is empty. `sh_load` is low, and `tx_ready` equals `tx_en`.
- R2: While `tx_en` is high, `tx_ready` is high exactly when no character is held.
- R3: A write (`wr_en` high) in a cycle where `tx_ready` is high stores `wr_data`, and `tx_ready` is low from the next cycle on.
- R4: `sh_load` is high in a cycle exactly when `tx_en` is high, a character is held and `sh_idle` is high. In that cycle `sh_data` carries the held character.
- R5: In the cycle after a handoff, `tx_ready` is high again if `tx_en` is still high.
- R6: `tx_ready` rises in the same cycle that `tx_en` rises.
- R7: `tx_ready` and `sh_load` are low in every cycle where `tx_en` is low.
- R8: A write made while `tx_en` is low is discarded. After enabling, no `sh_load` follows from it.
- R9: Deasserting `tx_en` while a character is held discards that character.
- R10: A write while enabled and not ready is ignored. The held character, seen on `sh_data`, is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| wr_en | input | 1 | Processor write strobe for the holding stage |
| wr_data | input | DATA_W | Character written by the processor |
| tx_ready | output | 1 | Holding stage is empty and the transmitter is enabled |
| sh_idle | input | 1 | Shift register can accept a character this cycle |
| sh_load | output | 1 | Character handed to the shift register this cycle |
| sh_data | output | DATA_W | Held character |

## Verification
The only hidden state is the held/empty flag and the character register. A wrong flag shows on `tx_ready` in the same cycle it goes wrong. It also shows on `sh_load` in the first cycle where `sh_idle` is high. A corrupted or overwritten character shows on `sh_data` at the next handoff. The bench compares ready, load and handoff data against a behavioural model on every clock, so a divergence is reported within one cycle of becoming visible.

// File: rtl/txhold_ctrl.sv
module txhold_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_ready,
  input  logic              sh_idle,
  output logic              sh_load,
  output logic [DATA_W-1:0] sh_data
);

  logic              held;
  logic [DATA_W-1:0] hold_q;

  assign tx_ready = tx_en & ~held;
  assign sh_load  = tx_en & held & sh_idle;
  assign sh_data  = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held <= 1'b0;
    end else if (!tx_en || sh_load) begin
      held <= 1'b0;
    end else if (wr_en && !held) begin
      held <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (tx_en && wr_en && !held) begin
      hold_q <= wr_data;
    end
  end

endmodule

module txhold_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              wr_en,
  input logic              tx_ready,
  input logic              sh_idle,
  input logic              sh_load,
  input logic [DATA_W-1:0] sh_data
);

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (!tx_ready && !sh_load));

  a_r4_load_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |-> (sh_idle && !tx_ready));

  a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && wr_en) |=> !tx_ready);

  a_r5_handoff_frees: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |=> (!tx_en || tx_ready));

  a_r6_ready_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> tx_ready);

  a_r10_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tx_ready && !sh_load) |=> (!tx_en || (!tx_ready && $stable(sh_data))));

endmodule

bind txhold_ctrl txhold_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en),
  .tx_ready(tx_ready), .sh_idle(sh_idle), .sh_load(sh_load), .sh_data(sh_data)
);

// File: tb/txhold_ctrl_tb.sv
`timescale 1ns/100ps
module txhold_ctrl_tb;
  localparam int DATA_W = 8;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              tx_en = 0;
  logic              wr_en = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              sh_idle = 0;
  logic              tx_ready, sh_load;
  logic [DATA_W-1:0] sh_data;

  int checks = 0;
  int errors = 0;
  bit m_full = 0;
  int m_data = 0;
  int loads = 0;

  always #2 clk = ~clk;

  txhold_ctrl #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data),
    .tx_ready(tx_ready), .sh_idle(sh_idle), .sh_load(sh_load), .sh_data(sh_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string req, input bit en, input bit wr, input int d, input bit idle);
    bit e_rdy, e_ld;
    @(negedge clk);
    tx_en = en; wr_en = wr; wr_data = d[DATA_W-1:0]; sh_idle = idle;
    #1;
    e_rdy = en && !m_full;
    e_ld  = en && m_full && idle;
    chk({req, " ready"}, int'(tx_ready), int'(e_rdy));
    chk({req, " load"}, int'(sh_load), int'(e_ld));
    if (e_ld) begin
      chk({req, " data"}, int'(sh_data), m_data);
      loads++;
    end
    if (!en || e_ld) m_full = 0;
    else if (wr && !m_full) begin m_full = 1; m_data = d; end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ready in reset", int'(tx_ready), 0);
    chk("R1 load in reset", int'(sh_load), 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 ready after reset", int'(tx_ready), 0);

    // R7/R8: disabled writes dropped
    step("R7 disabled idle", 0, 0, 0, 1);
    step("R8 disabled write", 0, 1, 8'h5A, 1);
    step("R8 disabled write2", 0, 1, 8'h11, 0);
    // R6: enable, ready at once
    step("R6 enable", 1, 0, 0, 1);
    step("R8 no stale load", 1, 0, 0, 1);
    // R3: write, then R10 overwrite ignored
    step("R3 write", 1, 1, 8'hA5, 0);
    step("R3 now full", 1, 0, 0, 0);
    step("R10 overwrite", 1, 1, 8'h3C, 0);
    // R4/R5 handoff
    step("R4 handoff", 1, 0, 0, 1);
    step("R5 ready again", 1, 0, 0, 1);
    chk("R10 held data went out", int'(sh_data), 8'hA5);
    // R9: disable while full
    step("R3 write2", 1, 1, 8'h77, 0);
    step("R9 disable full", 0, 0, 0, 1);
    step("R9 reenable", 1, 0, 0, 1);
    step("R9 no load", 1, 0, 0, 1);
    // R2 back-to-back write/handoff
    for (int i = 0; i < 6; i++) step("R2 b2b", 1, 1, 8'h20 + i, 1);
    // random mix
    for (int i = 0; i < 3000; i++)
      step("R2 random", ($urandom % 8) != 0, $urandom % 2, $urandom % 256, $urandom % 2);
    chk("R4 handoffs seen", int'(loads > 100), 1);
    finish_run();
  end
endmodule